// File: doc/BRIEF.md
# Cascaded Sink-Driver Chain Loader

This block is a host-side sequencer that loads a chain of cascaded 8-bit serial-in, latched-output sink drivers. It takes one parallel word of `N_DEV*8` bits over a valid/ready input. It sends the word out as serial data with a shift clock, and then raises a strobe that copies the shifted pattern into the drivers' output latches. Every minimum time on the chain side is a parameter given in whole system clock cycles: data setup before the rising shift edge, data hold after it, clock high width, clock low width, the gap before the strobe, and the strobe width.

The word is sent most significant bit first. Each shift moves data one stage toward the far end of the chain, so bit `N_DEV*8-1` comes to rest in the highest stage of the device farthest from the loader. Bit 0 rests in the lowest stage of the nearest device. The block can also drive an active-low clear pulse to the chain. It also drives an active-low output enable. That enable follows a level input, and it can blank the outputs for the whole load, with a guaranteed minimum blanking width.

Input handshake: a word is taken in any cycle where `in_valid` and `in_ready` are both high. `in_ready` is high only when the sequencer is idle and no clear request is present in the same cycle. The block holds no queue. A producer that keeps `in_valid` high while `in_ready` is low has its word taken in the first cycle in which `in_ready` returns high. The word is copied at acceptance, so `in_word` may change freely afterwards.

Top module: `chain_loader`

## Requirements
- R1: After reset, `drv_sclk`, `drv_stb`, `drv_sdata`, `busy` and `done` are 0, `drv_oe_n` and `drv_clr_n` are 1, and `in_ready` is 1.
- R2: A word is accepted only in a cycle where `in_valid` and `in_ready` are both high. `in_ready` is 0 from the cycle after acceptance until `busy` falls, and `in_valid` has no effect while `in_ready` is 0.
- R3: One load issues exactly `N_DEV*8` shift-clock pulses. The k-th pulse (k = 0 first) carries word bit `N_DEV*8-1-k`, so the first bit sent ends in the last stage of the farthest device.
- R4: `drv_sdata` takes each new bit `SETUP_CYC` cycles before the rising edge of `drv_sclk`. The first bit appears in the cycle after acceptance.
- R5: `drv_sclk` stays high for `HIGH_CYC` cycles and then low for max(`LOW_CYC`, `HOLD_CYC`) cycles. `drv_sdata` does not change while the clock is high or during that low phase. The bit period is `SETUP_CYC + HIGH_CYC + max(LOW_CYC, HOLD_CYC)`.
- R6: `drv_stb` rises exactly `HIGH_CYC + max(LOW_CYC,HOLD_CYC) + GAP_CYC` cycles after the last rising edge of `drv_sclk`. `drv_sclk` stays low while `drv_stb` is high.
- R7: `drv_stb` stays high for exactly `STB_CYC` cycles, once per load.
- R8: `done` is high for exactly one cycle, the cycle after the strobe falls (later if blanking is still running, see R9). `busy` is high from the cycle after acceptance through the `done` cycle.
- R9: `drv_oe_n` is the inverse of `outputs_on`, with one cycle of latency. With `BLANK_ON_LOAD=1`, it is also forced high from the cycle after acceptance until `done`, and that blanking lasts at least `BLANK_CYC` cycles: `done` waits for it.
- R10: `clr_req` high while idle drives `drv_clr_n` low for `CLR_CYC` cycles starting the next cycle, with `busy` high, no `done` and no shifting. Clear takes priority over a word offered in the same cycle (`in_ready` is 0). `clr_req` has no effect while busy.
- R11: Changes on `in_word` after acceptance do not change the bits shifted out.
- R12: `drv_sclk` and `drv_stb` are low whenever `busy` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Word offered |
| in_ready | output | 1 | Word can be accepted this cycle |
| in_word | input | N_DEV*8 | Pattern for the whole chain, MSB to farthest device |
| clr_req | input | 1 | Request a clear pulse to the chain |
| outputs_on | input | 1 | Level request to enable the driver outputs |
| busy | output | 1 | Load or clear sequence in progress |
| done | output | 1 | One-cycle pulse at the end of a load |
| drv_sclk | output | 1 | Shift clock to the chain |
| drv_sdata | output | 1 | Serial data to the chain |
| drv_stb | output | 1 | Latch strobe to the chain |
| drv_oe_n | output | 1 | Active-low output enable to the chain |
| drv_clr_n | output | 1 | Active-low register clear to the chain |

## Verification
All outputs are registered from the sequencer's next state. With acceptance at edge E0, the first data bit is visible after E0, the k-th rising clock after edge E0 + `SETUP_CYC` + k·period, the strobe after E0 + bits·period + `GAP_CYC`, and `done` after the strobe falls or when the blanking minimum ends, whichever is later. The bench drives and samples on the falling clock edge and indexes each sample by the number of rising edges since acceptance. It compares every output in every cycle of a load against a waveform computed from these formulas. A second instance has a blanking minimum longer than its load, so the extended `done` time is checked.

// File: rtl/chain_loader_pkg.sv
package chain_loader_pkg;

  typedef enum logic [3:0] {
    LD_IDLE,
    LD_CLEAR,
    LD_SETUP,
    LD_HIGH,
    LD_LOW,
    LD_GAP,
    LD_STROBE,
    LD_BLANK_WAIT,
    LD_DONE
  } ld_state_e;

  function automatic int at_least_one(input int a);
    return (a < 1) ? 1 : a;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/chain_loader_timer.sv
module chain_loader_timer #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign zero = (cnt_q == '0);

endmodule

// File: rtl/chain_loader_shreg.sv
module chain_loader_shreg #(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture,
  input  logic              shift,
  input  logic [WORD_W-1:0] word,
  output logic              nxt_bit,
  output logic              last_bit
);

  localparam int CW = (WORD_W > 1) ? $clog2(WORD_W) : 1;

  logic [WORD_W-1:0] hold_q;
  logic [CW-1:0]     left_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
      left_q <= '0;
    end else if (capture) begin
      hold_q <= word;
      left_q <= CW'(WORD_W - 1);
    end else if (shift) begin
      hold_q <= {hold_q[WORD_W-2:0], 1'b0};
      left_q <= left_q - 1'b1;
    end
  end

  // bit that will be on the serial line after this edge
  always_comb begin
    if (capture)    nxt_bit = word[WORD_W-1];
    else if (shift) nxt_bit = hold_q[WORD_W-2];
    else            nxt_bit = hold_q[WORD_W-1];
  end

  assign last_bit = (left_q == '0);

endmodule

// File: rtl/chain_loader_fsm.sv
module chain_loader_fsm
  import chain_loader_pkg::*;
#(
  parameter int TW     = 4,
  parameter int SU     = 1,
  parameter int HI     = 1,
  parameter int LO     = 1,
  parameter int GP     = 1,
  parameter int SB     = 1,
  parameter int CL     = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic          clr_req,
  input  logic          last_bit,
  input  logic          ph_zero,
  input  logic          blank_met,
  output ld_state_e     state_q,
  output ld_state_e     state_d,
  output logic          capture,
  output logic          shift,
  output logic          ph_load,
  output logic [TW-1:0] ph_val,
  output logic          blank_load
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= LD_IDLE;
    else        state_q <= state_d;
  end

  always_comb begin
    state_d    = state_q;
    capture    = 1'b0;
    shift      = 1'b0;
    ph_load    = 1'b0;
    ph_val     = '0;
    blank_load = 1'b0;
    unique case (state_q)
      LD_IDLE: begin
        if (clr_req) begin
          state_d = LD_CLEAR;
          ph_load = 1'b1;
          ph_val  = TW'(CL - 1);
        end else if (in_valid) begin
          state_d    = LD_SETUP;
          capture    = 1'b1;
          blank_load = 1'b1;
          ph_load    = 1'b1;
          ph_val     = TW'(SU - 1);
        end
      end
      LD_CLEAR: begin
        if (ph_zero) state_d = LD_IDLE;
      end
      LD_SETUP: begin
        if (ph_zero) begin
          state_d = LD_HIGH;
          ph_load = 1'b1;
          ph_val  = TW'(HI - 1);
        end
      end
      LD_HIGH: begin
        if (ph_zero) begin
          state_d = LD_LOW;
          ph_load = 1'b1;
          ph_val  = TW'(LO - 1);
        end
      end
      LD_LOW: begin
        if (ph_zero) begin
          ph_load = 1'b1;
          if (last_bit) begin
            state_d = LD_GAP;
            ph_val  = TW'(GP - 1);
          end else begin
            state_d = LD_SETUP;
            shift   = 1'b1;
            ph_val  = TW'(SU - 1);
          end
        end
      end
      LD_GAP: begin
        if (ph_zero) begin
          state_d = LD_STROBE;
          ph_load = 1'b1;
          ph_val  = TW'(SB - 1);
        end
      end
      LD_STROBE: begin
        if (ph_zero) state_d = blank_met ? LD_DONE : LD_BLANK_WAIT;
      end
      LD_BLANK_WAIT: begin
        if (blank_met) state_d = LD_DONE;
      end
      LD_DONE: state_d = LD_IDLE;
      default: state_d = LD_IDLE;
    endcase
  end

endmodule

// File: rtl/chain_loader.sv
module chain_loader
  import chain_loader_pkg::*;
#(
  parameter int N_DEV         = 2,
  parameter int BITS_PER_DEV  = 8,
  parameter int SETUP_CYC     = 1,
  parameter int HIGH_CYC      = 2,
  parameter int LOW_CYC       = 1,
  parameter int HOLD_CYC      = 1,
  parameter int GAP_CYC       = 3,
  parameter int STB_CYC       = 2,
  parameter int BLANK_CYC     = 8,
  parameter int CLR_CYC       = 2,
  parameter int BLANK_ON_LOAD = 1
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          in_valid,
  output logic                          in_ready,
  input  logic [N_DEV*BITS_PER_DEV-1:0] in_word,
  input  logic                          clr_req,
  input  logic                          outputs_on,
  output logic                          busy,
  output logic                          done,
  output logic                          drv_sclk,
  output logic                          drv_sdata,
  output logic                          drv_stb,
  output logic                          drv_oe_n,
  output logic                          drv_clr_n
);

  localparam int WORD_W = N_DEV * BITS_PER_DEV;
  localparam int SU     = at_least_one(SETUP_CYC);
  localparam int HI     = at_least_one(HIGH_CYC);
  localparam int LO     = at_least_one(imax(LOW_CYC, HOLD_CYC));
  localparam int GP     = at_least_one(GAP_CYC);
  localparam int SB     = at_least_one(STB_CYC);
  localparam int CL     = at_least_one(CLR_CYC);
  localparam int BK     = at_least_one(BLANK_CYC);
  localparam int PH_MAX = imax(imax(imax(SU, HI), imax(LO, GP)), imax(SB, CL));
  localparam int TW     = $clog2(PH_MAX + 1);
  localparam int BW     = $clog2(BK + 1);

  ld_state_e     state_q, state_d;
  logic          capture, shift, ph_load, ph_zero, blank_load, blank_zero;
  logic          blank_met, last_bit, nxt_bit, blanking_d;
  logic [TW-1:0] ph_val;

  chain_loader_fsm #(
    .TW(TW), .SU(SU), .HI(HI), .LO(LO), .GP(GP), .SB(SB), .CL(CL)
  ) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .clr_req   (clr_req),
    .last_bit  (last_bit),
    .ph_zero   (ph_zero),
    .blank_met (blank_met),
    .state_q   (state_q),
    .state_d   (state_d),
    .capture   (capture),
    .shift     (shift),
    .ph_load   (ph_load),
    .ph_val    (ph_val),
    .blank_load(blank_load)
  );

  chain_loader_timer #(.W(TW)) u_phase (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (ph_load),
    .load_val(ph_val),
    .zero    (ph_zero)
  );

  chain_loader_timer #(.W(BW)) u_blank (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (blank_load),
    .load_val(BW'(BK - 1)),
    .zero    (blank_zero)
  );

  chain_loader_shreg #(.WORD_W(WORD_W)) u_shreg (
    .clk     (clk),
    .rst_n   (rst_n),
    .capture (capture),
    .shift   (shift),
    .word    (in_word),
    .nxt_bit (nxt_bit),
    .last_bit(last_bit)
  );

  assign blank_met = (BLANK_ON_LOAD != 0) ? blank_zero : 1'b1;

  generate
    if (BLANK_ON_LOAD != 0) begin : g_blank
      assign blanking_d = (state_d != LD_IDLE) && (state_d != LD_CLEAR) &&
                          (state_d != LD_DONE);
    end else begin : g_noblank
      assign blanking_d = 1'b0;
    end
  endgenerate

  assign in_ready = (state_q == LD_IDLE) && !clr_req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      done      <= 1'b0;
      drv_sclk  <= 1'b0;
      drv_sdata <= 1'b0;
      drv_stb   <= 1'b0;
      drv_oe_n  <= 1'b1;
      drv_clr_n <= 1'b1;
    end else begin
      busy      <= (state_d != LD_IDLE);
      done      <= (state_d == LD_DONE);
      drv_sclk  <= (state_d == LD_HIGH);
      drv_sdata <= nxt_bit;
      drv_stb   <= (state_d == LD_STROBE);
      drv_oe_n  <= !outputs_on || blanking_d;
      drv_clr_n <= (state_d != LD_CLEAR);
    end
  end

endmodule

// File: rtl/chain_loader_chk.sv
module chain_loader_chk #(
  parameter int HIGH_CYC      = 2,
  parameter int LOW_CYC       = 1,
  parameter int HOLD_CYC      = 1,
  parameter int GAP_CYC       = 3,
  parameter int BLANK_ON_LOAD = 1
) (
  input logic clk,
  input logic rst_n,
  input logic in_ready,
  input logic busy,
  input logic done,
  input logic drv_sclk,
  input logic drv_sdata,
  input logic drv_stb,
  input logic drv_oe_n,
  input logic drv_clr_n
);

  localparam int HI     = (HIGH_CYC < 1) ? 1 : HIGH_CYC;
  localparam int LO_RAW = (LOW_CYC > HOLD_CYC) ? LOW_CYC : HOLD_CYC;
  localparam int LO     = (LO_RAW < 1) ? 1 : LO_RAW;
  localparam int GP     = (GAP_CYC < 1) ? 1 : GAP_CYC;
  localparam int MIN_GAP = HI + LO + GP;

  logic        sclk_d;
  logic [15:0] since_rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d     <= 1'b0;
      since_rise <= 16'hffff;
    end else begin
      sclk_d <= drv_sclk;
      if (drv_sclk && !sclk_d)       since_rise <= 16'd1;
      else if (since_rise != 16'hffff) since_rise <= since_rise + 16'd1;
    end
  end

  p_ready_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !in_ready);

  p_data_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (drv_sclk || $fell(drv_sclk)) |-> $stable(drv_sdata));

  p_strobe_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drv_stb) |-> (since_rise >= 16'(MIN_GAP)));

  p_no_clk_in_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
    drv_stb |-> !drv_sclk);

  p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_in_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy);

  p_blank_shift_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((BLANK_ON_LOAD != 0) && drv_sclk) |-> drv_oe_n);

  p_clear_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !drv_clr_n |-> (busy && !drv_sclk && !drv_stb && !done));

  p_idle_low_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!drv_sclk && !drv_stb));

endmodule

bind chain_loader chain_loader_chk #(
  .HIGH_CYC(HIGH_CYC), .LOW_CYC(LOW_CYC), .HOLD_CYC(HOLD_CYC),
  .GAP_CYC(GAP_CYC), .BLANK_ON_LOAD(BLANK_ON_LOAD)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_ready (in_ready),
  .busy     (busy),
  .done     (done),
  .drv_sclk (drv_sclk),
  .drv_sdata(drv_sdata),
  .drv_stb  (drv_stb),
  .drv_oe_n (drv_oe_n),
  .drv_clr_n(drv_clr_n)
);

// File: tb/chain_loader_bench.sv
module chain_loader_bench;

  localparam int CLK_PERIOD = 10;
  localparam int SU = 1, HI = 2, LO = 1, GP = 3, SB = 2, CL = 2;
  localparam int PER = SU + HI + LO;
  localparam int BLANK_A = 8, BLANK_B = 40;

  logic clk = 1'b0, rst_n = 1'b0;
  logic valid_a = 1'b0, valid_b = 1'b0, clr_req = 1'b0, outputs_on = 1'b0;
  logic [15:0] in_word = '0;
  int n_checks = 0, n_errs = 0;
  bit sel = 1'b0;

  logic rdy_a, busy_a, done_a, sclk_a, sdata_a, stb_a, oen_a, clrn_a;
  logic rdy_b, busy_b, done_b, sclk_b, sdata_b, stb_b, oen_b, clrn_b;

  always #(CLK_PERIOD/2) clk = ~clk;

  chain_loader #(
    .N_DEV(2), .BITS_PER_DEV(8), .SETUP_CYC(SU), .HIGH_CYC(HI), .LOW_CYC(LO),
    .HOLD_CYC(1), .GAP_CYC(GP), .STB_CYC(SB), .BLANK_CYC(BLANK_A),
    .CLR_CYC(CL), .BLANK_ON_LOAD(1)
  ) u_chain_loader (
    .clk(clk), .rst_n(rst_n), .in_valid(valid_a), .in_ready(rdy_a),
    .in_word(in_word), .clr_req(clr_req), .outputs_on(outputs_on),
    .busy(busy_a), .done(done_a), .drv_sclk(sclk_a), .drv_sdata(sdata_a),
    .drv_stb(stb_a), .drv_oe_n(oen_a), .drv_clr_n(clrn_a)
  );

  chain_loader #(
    .N_DEV(1), .BITS_PER_DEV(8), .SETUP_CYC(SU), .HIGH_CYC(HI), .LOW_CYC(LO),
    .HOLD_CYC(1), .GAP_CYC(GP), .STB_CYC(SB), .BLANK_CYC(BLANK_B),
    .CLR_CYC(CL), .BLANK_ON_LOAD(1)
  ) u_chain_loader_b (
    .clk(clk), .rst_n(rst_n), .in_valid(valid_b), .in_ready(rdy_b),
    .in_word(in_word[7:0]), .clr_req(1'b0), .outputs_on(outputs_on),
    .busy(busy_b), .done(done_b), .drv_sclk(sclk_b), .drv_sdata(sdata_b),
    .drv_stb(stb_b), .drv_oe_n(oen_b), .drv_clr_n(clrn_b)
  );

  wire o_rdy   = sel ? rdy_b   : rdy_a;
  wire o_busy  = sel ? busy_b  : busy_a;
  wire o_done  = sel ? done_b  : done_a;
  wire o_sclk  = sel ? sclk_b  : sclk_a;
  wire o_sdata = sel ? sdata_b : sdata_a;
  wire o_stb   = sel ? stb_b   : stb_a;
  wire o_oen   = sel ? oen_b   : oen_a;

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errs++;
      $display("FAIL %s: actual %0d expected %0d at %0t", what, act, exp, $time);
    end
  endtask

  task automatic test_reset();
    chk(sclk_a == 0 && stb_a == 0 && sdata_a == 0, "R1 sclk/stb/sdata reset", {sclk_a, stb_a, sdata_a}, 0);
    chk(busy_a == 0 && done_a == 0, "R1 busy/done reset", {busy_a, done_a}, 0);
    chk(oen_a == 1 && clrn_a == 1, "R1 oe_n/clr_n reset", {oen_a, clrn_a}, 3);
    chk(rdy_a == 1, "R1 in_ready reset", rdy_a, 1);
  endtask

  // one full load; every output compared every cycle against the computed waveform
  task automatic run_load(input bit use_b, input logic [15:0] word, input bit on,
                          input bit change_word, input bit hold_valid, input bit poke_clr);
    int nbits, stb_start, stb_end, blank, done_idx, last_rise, stb_rise, pulses;
    logic prev_sclk, prev_stb;
    nbits     = use_b ? 8 : 16;
    blank     = use_b ? BLANK_B : BLANK_A;
    stb_start = nbits * PER + GP;
    stb_end   = stb_start + SB;
    done_idx  = (stb_end > blank) ? stb_end : blank;
    last_rise = -1; stb_rise = -1; pulses = 0;
    prev_sclk = 1'b0; prev_stb = 1'b0;
    @(negedge clk);
    sel = use_b; outputs_on = on; in_word = word;
    if (use_b) valid_b = 1'b1; else valid_a = 1'b1;
    @(negedge clk);
    if (!hold_valid) begin valid_a = 1'b0; valid_b = 1'b0; end
    if (change_word) in_word = ~word;
    for (int idx = 0; idx <= done_idx + 3; idx++) begin
      bit e_sclk, e_stb, e_busy, e_done, e_oen;
      e_sclk = (idx < nbits * PER) && ((idx % PER) >= SU) && ((idx % PER) < SU + HI);
      e_stb  = (idx >= stb_start) && (idx < stb_end);
      e_busy = (idx <= done_idx);
      e_done = (idx == done_idx);
      e_oen  = !on || (idx < done_idx);
      chk(o_sclk == e_sclk, $sformatf("R4/R5 sclk idx %0d", idx), o_sclk, e_sclk);
      if (idx < nbits * PER)
        chk(o_sdata == word[nbits - 1 - idx / PER],
            $sformatf("%s sdata idx %0d", change_word ? "R11" : "R3", idx),
            o_sdata, word[nbits - 1 - idx / PER]);
      chk(o_stb == e_stb, $sformatf("R7 stb idx %0d", idx), o_stb, e_stb);
      chk(o_busy == e_busy, $sformatf("R8 busy idx %0d", idx), o_busy, e_busy);
      chk(o_done == e_done, $sformatf("R8 done idx %0d", idx), o_done, e_done);
      chk(o_oen == e_oen, $sformatf("R9 oe_n idx %0d", idx), o_oen, e_oen);
      if (idx < done_idx) chk(o_rdy == 0, $sformatf("R2 in_ready idx %0d", idx), o_rdy, 0);
      if (!o_busy) chk(!o_sclk && !o_stb, "R12 idle low", {o_sclk, o_stb}, 0);
      if (poke_clr) chk(clrn_a == 1, $sformatf("R10 clr ignored idx %0d", idx), clrn_a, 1);
      if (o_sclk && !prev_sclk) begin last_rise = idx; pulses++; end
      if (o_stb && !prev_stb) stb_rise = idx;
      prev_sclk = o_sclk; prev_stb = o_stb;
      @(negedge clk);
      if (poke_clr && idx == 10) clr_req = 1'b1;
      if (poke_clr && idx == 11) clr_req = 1'b0;
      if (hold_valid && idx == done_idx - 1) begin valid_a = 1'b0; valid_b = 1'b0; end
    end
    chk(pulses == nbits, "R3 pulse count", pulses, nbits);
    chk(stb_rise - last_rise == HI + LO + GP, "R6 strobe gap", stb_rise - last_rise, HI + LO + GP);
    in_word = '0;
  endtask

  task automatic test_clear();
    @(negedge clk);
    sel = 1'b0; clr_req = 1'b1; valid_a = 1'b1;
    #1;
    chk(rdy_a == 0, "R10 clear priority in_ready", rdy_a, 0);
    @(negedge clk);
    clr_req = 1'b0; valid_a = 1'b0;
    for (int idx = 0; idx < 5; idx++) begin
      chk(clrn_a == (idx >= CL), $sformatf("R10 clr_n idx %0d", idx), clrn_a, idx >= CL);
      chk(busy_a == (idx < CL), $sformatf("R10 busy idx %0d", idx), busy_a, idx < CL);
      chk(!sclk_a && !done_a, $sformatf("R10 no shift idx %0d", idx), {sclk_a, done_a}, 0);
      @(negedge clk);
    end
  endtask

  task automatic test_enable_level();
    @(negedge clk);
    sel = 1'b0; outputs_on = 1'b1;
    @(negedge clk);
    chk(oen_a == 0, "R9 oe_n follows on", oen_a, 0);
    outputs_on = 1'b0;
    @(negedge clk);
    chk(oen_a == 1, "R9 oe_n follows off", oen_a, 1);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_errs++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    test_reset();
    run_load(1'b0, 16'hA5C3, 1'b1, 1'b0, 1'b0, 1'b0);
    run_load(1'b0, 16'h0001, 1'b1, 1'b1, 1'b1, 1'b0);
    run_load(1'b0, 16'hFF00, 1'b0, 1'b0, 1'b0, 1'b1);
    run_load(1'b1, 16'h005A, 1'b1, 1'b0, 1'b0, 1'b0);
    test_clear();
    test_enable_level();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
    $finish;
  end

endmodule